// File: doc/BRIEF.md
# Subband Sample Requantizer and Rescaler

This block turns one coded subband sample into a rescaled fixed-point value. Each input beat carries three things: the raw sample code, the number of bits the code uses, and a scalefactor word. The block recovers the signed fraction the code stands for and adds the small offset that re-centres the quantizer step. It multiplies the result by the gain for that bit count, 2^nb / (2^nb − 1), and then by the scalefactor.

Every internal value and the output use one signed 32-bit fixed-point word. That word has 4 integer bits, the sign included, and 28 fractional bits. Each product is rounded back to this word and saturates if it does not fit.

The input and the output each use a valid/ready handshake. The datapath is a three-stage pipeline that moves only as a whole. A result waiting at the output holds the entire pipeline in place until the consumer takes it.

Top module: `rq_requant`

## Requirements
- R1: The sample code is the low nb bits of `in_sample`, read as two's complement with bit nb−1 as the sign. Bits at positions nb and above have no effect on the result.
- R2: For 2 ≤ nb ≤ 15 the requantized word is T × G rounded, with T = (code + 1) · 2^(29−nb) and G = ⌊(2^(28+nb) + ⌊(2^nb − 1)/2⌋) / (2^nb − 1)⌋. T is the sample fraction plus the offset 2^(1−nb), both in 28-fraction-bit units.
- R3: Each product rounds half-up. It adds 2^27 to the full 64-bit product and then shifts right arithmetically by 28.
- R4: A rounded product above 0x7FFFFFFF gives 0x7FFFFFFF. A rounded product below −2^31 gives 0x80000000.
- R5: `out_data` is the requantized word times `in_scale`, taken as a signed 4.28 word, rounded per R3 and saturated per R4.
- R6: An allocation of nb = 0, nb = 1, or any value outside 2..15 still produces an output beat, and that beat's `out_data` is 0.
- R7: With `out_ready` held high, a beat accepted at one rising edge is presented on `out_valid`/`out_data` after the second rising edge that follows. The handshake completes three cycles after acceptance, and at most three beats are in flight.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low.
- R9: During and right after synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R10: Results leave in the order their inputs were accepted, one per accepted input, and no output beat appears without an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat taken at this edge when valid |
| in_sample | input | 16 | Sample code in the low nb bits |
| in_nb | input | 4 | Bits allocated to the sample |
| in_scale | input | 32 | Scalefactor, signed 4.28 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_data | output | 32 | Rescaled sample, signed 4.28 |

## Verification
The bench drives the code sign bit into both states at the smallest and largest allocations, and it fills the bits above the code with noise. A block that read the wrong sign bit or let the upper bits leak in would put out values off by whole quantizer steps. Scalefactors of ±8 push the products past the word range; dropping saturation would wrap them to the opposite sign. Random beats are compared bit-exactly against a model, which catches any rounding that truncates or rounds toward zero by one LSB. Random stalls on `out_ready` catch a pipeline that drops, repeats or reorders beats, or changes its output while held. A directed beat measures the three-cycle latency.

// File: rtl/rq_pkg.sv
package rq_pkg;

   // Gain 2^nb/(2^nb-1) as a fixed-point integer with frac fractional
   // bits, rounded to nearest.
   function automatic longint rq_gain_val(input int nb, input int frac);
      longint num;
      longint den;
      num = longint'(1) << (frac + nb);
      den = (longint'(1) << nb) - 1;
      return (num + den / 2) / den;
   endfunction

endpackage

// File: rtl/rq_front.sv
module rq_front
   import rq_pkg::*;
#(
   parameter int W      = 32,
   parameter int FRAC   = 28,
   parameter int SMP_W  = 16,
   parameter int NB_W   = 4,
   parameter int NB_MIN = 2,
   parameter int NB_MAX = 15
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                adv,
   input  logic                in_vld,
   input  logic [SMP_W-1:0]    sample,
   input  logic [NB_W-1:0]     nb,
   input  logic [W-1:0]        sf,
   output logic                s1_vld,
   output logic signed [W-1:0] s1_t,
   output logic signed [W-1:0] s1_gain,
   output logic signed [W-1:0] s1_sf
);

   localparam int NB_N = 2 ** NB_W;
   localparam int SH_W = $clog2(SMP_W + 1);
   localparam int FS_W = $clog2(W);

   // elaboration-time parameter checks
   if (NB_MAX > SMP_W) begin : g_bad_smp
      $error("rq_front: NB_MAX exceeds sample width");
   end
   if (NB_MAX > FRAC + 1) begin : g_bad_frac
      $error("rq_front: NB_MAX too large for fraction bits");
   end
   if (NB_MAX >= NB_N) begin : g_bad_nbw
      $error("rq_front: NB_W too narrow for NB_MAX");
   end
   if (NB_MIN < 1 || NB_MIN > NB_MAX) begin : g_bad_min
      $error("rq_front: bad NB_MIN");
   end
   if (FRAC + NB_MAX > 61) begin : g_bad_gain
      $error("rq_front: gain numerator overflows");
   end

   // per-allocation gain table, computed at elaboration
   logic signed [W-1:0] gain_tab [NB_N];

   for (genvar g = 0; g < NB_N; g++) begin : g_gain
      if (g >= NB_MIN && g <= NB_MAX) begin : g_ok
         localparam longint GV = rq_gain_val(g, FRAC);
         assign gain_tab[g] = W'(GV);
      end else begin : g_zero
         assign gain_tab[g] = '0;
      end
   end

   // align the nb-bit code and add the half-step offset
   logic                    nb_ok;
   logic [SH_W-1:0]         lsh;
   logic [SMP_W-1:0]        up;
   logic signed [SMP_W-1:0] code_n;
   logic signed [W-1:0]     code_w;
   logic [FS_W-1:0]         rsh;
   logic signed [W-1:0]     t_c;

   always_comb begin
      nb_ok  = (nb >= NB_W'(NB_MIN)) && (nb <= NB_W'(NB_MAX));
      lsh    = SH_W'(SMP_W) - SH_W'(nb);
      up     = sample << lsh;
      code_n = $signed(up) >>> lsh;
      code_w = W'(code_n);
      rsh    = FS_W'(FRAC + 1) - FS_W'(nb);
      t_c    = nb_ok ? ((code_w + W'(1)) <<< rsh) : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld  <= 1'b0;
         s1_t    <= '0;
         s1_gain <= '0;
         s1_sf   <= '0;
      end else if (adv) begin
         s1_vld  <= in_vld;
         s1_t    <= t_c;
         s1_gain <= gain_tab[nb];
         s1_sf   <= $signed(sf);
      end
   end

endmodule

// File: rtl/rq_mulrnd.sv
module rq_mulrnd #(
   parameter int W    = 32,
   parameter int FRAC = 28
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                adv,
   input  logic                in_vld,
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic                out_vld,
   output logic signed [W-1:0] y
);

   localparam int PW = 2 * W;
   localparam logic signed [PW-1:0] YMAX = {{(W + 1){1'b0}}, {(W - 1){1'b1}}};
   localparam logic signed [PW-1:0] YMIN = {{(W + 1){1'b1}}, {(W - 1){1'b0}}};

   if (FRAC >= W - 1) begin : g_bad_frac
      $error("rq_mulrnd: FRAC must leave integer bits");
   end

   logic signed [PW-1:0] half;

   if (FRAC > 0) begin : g_round
      assign half = PW'(1) <<< (FRAC - 1);
   end else begin : g_trunc
      assign half = '0;
   end

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] sum;
   logic signed [PW-1:0] shf;
   logic signed [W-1:0]  y_c;

   always_comb begin
      prod = PW'(a) * PW'(b);
      sum  = prod + half;
      shf  = sum >>> FRAC;
      if (shf > YMAX)      y_c = YMAX[W-1:0];
      else if (shf < YMIN) y_c = YMIN[W-1:0];
      else                 y_c = shf[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
         y       <= '0;
      end else if (adv) begin
         out_vld <= in_vld;
         y       <= y_c;
      end
   end

endmodule

// File: rtl/rq_requant.sv
module rq_requant #(
   parameter int W      = 32,
   parameter int FRAC   = 28,
   parameter int SMP_W  = 16,
   parameter int NB_W   = 4,
   parameter int NB_MIN = 2,
   parameter int NB_MAX = 15
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [SMP_W-1:0] in_sample,
   input  logic [NB_W-1:0]  in_nb,
   input  logic [W-1:0]     in_scale,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [W-1:0]     out_data
);

   if (W < 8 || FRAC < 1) begin : g_bad_word
      $error("rq_requant: word format too small");
   end

   // the whole pipeline moves together unless a result is held
   logic adv;
   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   logic                s1_vld;
   logic signed [W-1:0] s1_t;
   logic signed [W-1:0] s1_gain;
   logic signed [W-1:0] s1_sf;

   rq_front #(
      .W(W), .FRAC(FRAC), .SMP_W(SMP_W),
      .NB_W(NB_W), .NB_MIN(NB_MIN), .NB_MAX(NB_MAX)
   ) front_i (
      .clk(clk), .rst(rst), .adv(adv), .in_vld(in_valid),
      .sample(in_sample), .nb(in_nb), .sf(in_scale),
      .s1_vld(s1_vld), .s1_t(s1_t), .s1_gain(s1_gain), .s1_sf(s1_sf)
   );

   // stage 2: requantize, scalefactor rides alongside
   logic                s2_vld;
   logic signed [W-1:0] s2_q;
   logic signed [W-1:0] s2_sf;

   rq_mulrnd #(.W(W), .FRAC(FRAC)) gain_mul_i (
      .clk(clk), .rst(rst), .adv(adv), .in_vld(s1_vld),
      .a(s1_t), .b(s1_gain), .out_vld(s2_vld), .y(s2_q)
   );

   always_ff @(posedge clk) begin
      if (rst)      s2_sf <= '0;
      else if (adv) s2_sf <= s1_sf;
   end

   // stage 3: rescale
   logic signed [W-1:0] s3_y;

   rq_mulrnd #(.W(W), .FRAC(FRAC)) scale_mul_i (
      .clk(clk), .rst(rst), .adv(adv), .in_vld(s2_vld),
      .a(s2_q), .b(s2_sf), .out_vld(out_valid), .y(s3_y)
   );

   assign out_data = s3_y;

endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic         in_ready,
   input logic         out_valid,
   input logic         out_ready,
   input logic [W-1:0] out_data
);

   logic [2:0] inflight;

   always_ff @(posedge clk) begin
      if (rst) inflight <= '0;
      else inflight <= inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
   end

   // R8
   hold_data_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R8
   backpressure_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);

   // R9
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !out_valid);

   // R7
   occupancy_chk: assert property (@(posedge clk) disable iff (rst)
      inflight <= 3'd3);

   // R10
   no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> inflight != 3'd0);

endmodule

bind rq_requant rq_requant_chk #(.W(W)) chk_i (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/rq_requant_tb_top.sv
`timescale 1ns/1ps
module rq_requant_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_sample = '0;
   logic [3:0]  in_nb = '0;
   logic [31:0] in_scale = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;

   always #2.5 clk = ~clk;

   rq_requant dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_sample(in_sample), .in_nb(in_nb), .in_scale(in_scale),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   int     n_run = 0;
   int     n_fail = 0;
   int     iter = 0;
   bit     lat_mode = 0;
   bit     prev_hold = 0;
   logic [31:0] prev_data = '0;
   longint exp_q[$];
   int     acc_q[$];
   string  tag_q[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic longint mr(input longint a, input longint b);
      longint p;
      p = a * b;
      p = p + (longint'(1) << 27);
      p = p >>> 28;
      if (p > 64'sd2147483647) p = 64'sd2147483647;
      if (p < -64'sd2147483648) p = -64'sd2147483648;
      return p;
   endfunction

   function automatic longint model(input int nb, input logic [15:0] smp, input logic [31:0] sf);
      longint code, t, g, den, q;
      if (nb < 2 || nb > 15) return 0;
      code = longint'(smp) & ((longint'(1) << nb) - 1);
      if (code >= (longint'(1) << (nb - 1))) code = code - (longint'(1) << nb);
      t   = (code + 1) * (longint'(1) << (29 - nb));
      den = (longint'(1) << nb) - 1;
      g   = ((longint'(1) << (28 + nb)) + den / 2) / den;
      q   = mr(t, g);
      return mr(q, longint'($signed(sf)));
   endfunction

   task automatic step(input bit iv, input logic [3:0] nbv, input logic [15:0] smp,
                       input logic [31:0] sfv, input bit ordy);
      longint e;
      int     a;
      string  tg;
      @(negedge clk);
      in_valid  = iv;
      in_nb     = nbv;
      in_sample = smp;
      in_scale  = sfv;
      out_ready = ordy;
      #1;
      iter++;
      if (prev_hold)
         chk(out_valid && out_data == prev_data, "R8 held output", longint'(out_data), longint'(prev_data));
      if (out_valid && !out_ready)
         chk(!in_ready, "R8 in_ready while held", longint'(in_ready), 0);
      if (in_valid && in_ready) begin
         exp_q.push_back(model(int'(nbv), smp, sfv));
         acc_q.push_back(iter);
         tag_q.push_back((nbv < 2) ? "R6 zero output" : "R1 R2 R3 R4 R5 R10 data");
      end
      if (out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            chk(0, "R10 unexpected beat", longint'(out_data), 0);
         end else begin
            e  = exp_q.pop_front();
            a  = acc_q.pop_front();
            tg = tag_q.pop_front();
            chk(longint'($signed(out_data)) == e, tg, longint'($signed(out_data)), e);
            if (lat_mode) chk(iter - a == 3, "R7 latency", iter - a, 3);
         end
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
   endtask

   task automatic drain();
      for (int k = 0; k < 8; k++) step(0, 4'd0, 16'h0, 32'h0, 1);
   endtask

   initial begin
      void'($urandom(1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 out_valid in reset", longint'(out_valid), 0);
      chk(in_ready == 1'b1, "R9 in_ready in reset", longint'(in_ready), 1);
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 out_valid after reset", longint'(out_valid), 0);

      // directed corners
      step(1, 4'd2,  16'h0001, 32'h1000_0000, 1); // +max code, scale 1.0
      step(1, 4'd2,  16'h0002, 32'h1000_0000, 1); // most negative code
      step(1, 4'd15, 16'h3FFF, 32'h2000_0000, 1); // max code, scale 2.0
      step(1, 4'd15, 16'hC000, 32'h2000_0000, 1); // min code, upper bit noise
      step(1, 4'd15, 16'h4000, 32'h0000_0001, 1); // tiny scale
      step(1, 4'd2,  16'hFFF1, 32'h7FFF_FFFF, 1); // positive saturation
      step(1, 4'd2,  16'h0001, 32'h8000_0000, 1); // negative saturation
      step(1, 4'd0,  16'h7FFF, 32'h7FFF_FFFF, 1); // zero allocation
      step(1, 4'd1,  16'h0001, 32'h1000_0000, 1); // below minimum
      step(1, 4'd7,  16'hAB40, 32'hF000_0000, 1); // upper bits set, negative scale
      step(1, 4'd7,  16'h0040, 32'hF000_0000, 1); // same code without noise
      drain();

      // random traffic with stalls
      for (int i = 0; i < 2500; i++) begin
         logic [3:0]  nbr;
         logic [31:0] sfr;
         int          sel;
         nbr = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 1)) : 4'($urandom_range(2, 15));
         sel = $urandom_range(0, 3);
         if (sel == 0)      sfr = $urandom();
         else if (sel == 1) sfr = $urandom() >> 8;
         else if (sel == 2) sfr = $urandom() >> 3;
         else               sfr = $urandom_range(0, 1) ? 32'h7FFF_FFFF : 32'h8000_0000;
         step($urandom_range(0, 9) < 7, nbr, 16'($urandom()), sfr, $urandom_range(0, 9) < 7);
      end
      drain();
      chk(exp_q.size() == 0, "R10 all beats delivered", exp_q.size(), 0);

      // latency
      lat_mode = 1;
      step(1, 4'd9, 16'h0123, 32'h1800_0000, 1);
      drain();
      lat_mode = 0;
      chk(exp_q.size() == 0, "R7 latency beat delivered", exp_q.size(), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule